// File: doc/BRIEF.md
# Wormhole Switch Allocator with Output Locking

This block decides, every cycle, which input of an N-by-N wormhole router may move its front flit to which output. Each input shows whether it holds a flit, the flit's kind, and the output port that routing picked for it. Each output shows whether its downstream neighbour can take a flit this cycle. The allocator masks these requests, runs one round-robin arbiter per output, and returns a dequeue strobe and a granted port for each input, plus a valid flag and a winning input index for each output. The crossbar control can use the per-output pair directly.

A packet holds its output from the grant of its head flit until its tail flit leaves. On a head grant the input records the output in a private register and marks itself locked, and the output is marked taken. Later body and tail flits of that packet ignore their own port field and request the stored port. They are still gated by the output's ready signal. A single-flit packet wins and releases in the same grant, so it never takes the output.

Top module: `sw_alloc`

## Requirements
- R1: Flit kind is a 2-bit code: 00 head, 01 body, 10 tail, 11 single-flit packet. An input that is not locked and presents a head or single-flit packet is granted only if it is valid, its destination output is free, and that output's ready input is high.
- R2: An input that is not locked and presents a body or tail flit is never granted.
- R3: A locked input requests its stored output whatever its current port field says. It is granted only while that output's ready input is high.
- R4: Each output grants at most one input per cycle, and each input is granted at most one output. An input's dequeue strobe is high exactly when some output names it as winner, and its granted-port output then names that output.
- R5: A granted head flit (00) locks its input to that output from the next cycle. Until the tail flit is granted, head and single-flit requests from every other input to that output are refused.
- R6: When a locked input's tail flit (10) is granted, the lock and the reservation both clear from the next cycle. Another input's head flit may then win that output.
- R7: A granted single-flit packet (11) from an unlocked input leaves the input unlocked and the output free. The same output may be won again on the next cycle.
- R8: Each output arbitrates round-robin. After a grant to an unlocked input's head or single-flit packet, the search for the next winner starts at the index just after that input, wrapping to 0. Grants to locked inputs leave the search position unchanged.
- R9: After reset no input is locked, every output is free, each arbiter starts its search at input 0, and with no valid inputs no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Front flit present, one bit per input |
| in_type | input | 2*NPORT | Flit kind per input, 2 bits each |
| in_dest | input | PW*NPORT | Routed output port per input |
| out_ready | input | NPORT | Downstream can accept a flit, one bit per output |
| in_deq | output | NPORT | Dequeue strobe per input (granted this cycle) |
| in_gnt_port | output | PW*NPORT | Output granted to each input, valid with in_deq |
| out_vld | output | NPORT | Output carries a granted flit this cycle |
| out_src | output | PW*NPORT | Winning input index per output |

## Verification
Several properties hold on every cycle: grant counts agree between the input and output views, no grant goes to an output whose ready is low, unlocked body and tail flits are never granted, a taken output is only granted to the input that owns it, each output's free flag matches the set of held locks, and head and single-flit grants have the right effect on the lock. The round-robin order, release timing after a tail, and re-winning after a single-flit packet depend on the sequence of past grants. These are shown only by the bench, through directed sequences and a long sweep of mixed traffic compared against a behavioural model.

// File: rtl/sa_pkg.sv
package sa_pkg;

   typedef enum logic [1:0] {
      FK_HEAD = 2'b00,
      FK_BODY = 2'b01,
      FK_TAIL = 2'b10,
      FK_SOLO = 2'b11
   } flit_kind_e;

   function automatic logic opens_pkt(input logic [1:0] k);
      return (k == FK_HEAD) || (k == FK_SOLO);
   endfunction

   function automatic logic closes_pkt(input logic [1:0] k);
      return (k == FK_TAIL) || (k == FK_SOLO);
   endfunction

endpackage

// File: rtl/sa_req_mask.sv
module sa_req_mask #(
   parameter int NPORT = 4,
   parameter int PW    = 2
) (
   input  logic             valid,
   input  logic [1:0]       kind,
   input  logic [PW-1:0]    dest,
   input  logic             locked,
   input  logic [PW-1:0]    held_port,
   input  logic [NPORT-1:0] out_free,
   input  logic [NPORT-1:0] out_ready,
   output logic [NPORT-1:0] req_vec,
   output logic [PW-1:0]    tgt,
   output logic             fresh
);
   import sa_pkg::*;

   logic in_range;
   logic free_ok;
   logic rdy_ok;
   logic ok;

   always_comb begin
      tgt      = locked ? held_port : dest;
      fresh    = !locked && opens_pkt(kind);
      in_range = (int'(tgt) < NPORT);
      free_ok  = 1'b0;
      rdy_ok   = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
         if (int'(tgt) == o) begin
            free_ok = out_free[o];
            rdy_ok  = out_ready[o];
         end
      end
      ok = valid && in_range && rdy_ok && (locked || (fresh && free_ok));
   end

   generate
      for (genvar o = 0; o < NPORT; o++) begin : g_col
         assign req_vec[o] = ok && (int'(tgt) == o);
      end
   endgenerate

endmodule

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
   parameter int NREQ = 4,
   parameter int IW   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req,
   input  logic            advance,
   output logic [NREQ-1:0] gnt,
   output logic [IW-1:0]   win,
   output logic            any
);
   localparam logic [IW-1:0] LAST = IW'(NREQ - 1);

   logic [IW-1:0] ptr;

   always_comb begin
      int idx;
      gnt = '0;
      win = '0;
      any = 1'b0;
      for (int k = 0; k < NREQ; k++) begin
         idx = int'(ptr) + k;
         if (idx >= NREQ) idx = idx - NREQ;
         if (!any && req[idx[IW-1:0]]) begin
            any                = 1'b1;
            gnt[idx[IW-1:0]]   = 1'b1;
            win                = idx[IW-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (advance && any) begin
         ptr <= (win == LAST) ? '0 : win + 1'b1;
      end
   end

endmodule

// File: rtl/sa_lock_state.sv
module sa_lock_state #(
   parameter int NPORT = 4,
   parameter int PW    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT-1:0]    deq,
   input  logic [NPORT*PW-1:0] gnt_port,
   input  logic [2*NPORT-1:0]  kind,
   input  logic [NPORT-1:0]    fresh,
   output logic [NPORT-1:0]    locked,
   output logic [NPORT*PW-1:0] held_port,
   output logic [NPORT-1:0]    out_free
);
   import sa_pkg::*;

   logic [NPORT-1:0] take;
   logic [NPORT-1:0] give;

   always_comb begin
      take = '0;
      give = '0;
      for (int i = 0; i < NPORT; i++) begin
         for (int o = 0; o < NPORT; o++) begin
            if (deq[i] && fresh[i] && kind[2*i +: 2] == FK_HEAD
                && int'(gnt_port[i*PW +: PW]) == o)
               take[o] = 1'b1;
            if (deq[i] && locked[i] && closes_pkt(kind[2*i +: 2])
                && int'(held_port[i*PW +: PW]) == o)
               give[o] = 1'b1;
         end
      end
   end

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_in
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               locked[i]            <= 1'b0;
               held_port[i*PW +: PW] <= '0;
            end else if (deq[i]) begin
               if (fresh[i] && kind[2*i +: 2] == FK_HEAD) begin
                  locked[i]            <= 1'b1;
                  held_port[i*PW +: PW] <= gnt_port[i*PW +: PW];
               end else if (locked[i] && closes_pkt(kind[2*i +: 2])) begin
                  locked[i] <= 1'b0;
               end
            end
         end
      end
      for (genvar o = 0; o < NPORT; o++) begin : g_out
         always_ff @(posedge clk) begin
            if (!rst_n)       out_free[o] <= 1'b1;
            else if (take[o]) out_free[o] <= 1'b0;
            else if (give[o]) out_free[o] <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/sw_alloc.sv
module sw_alloc #(
   parameter int NPORT = 4,
   parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT-1:0]    in_valid,
   input  logic [2*NPORT-1:0]  in_type,
   input  logic [NPORT*PW-1:0] in_dest,
   input  logic [NPORT-1:0]    out_ready,
   output logic [NPORT-1:0]    in_deq,
   output logic [NPORT*PW-1:0] in_gnt_port,
   output logic [NPORT-1:0]    out_vld,
   output logic [NPORT*PW-1:0] out_src
);
   generate
      if (NPORT < 2) begin : g_bad_n
         $error("sw_alloc: NPORT must be at least 2");
      end
      if ((1 << PW) < NPORT) begin : g_bad_pw
         $error("sw_alloc: PW too narrow for NPORT");
      end
   endgenerate

   logic [NPORT-1:0]    locked;
   logic [NPORT*PW-1:0] held_port;
   logic [NPORT-1:0]    out_free;
   logic [NPORT-1:0]    fresh;
   logic [NPORT*PW-1:0] tgt;
   logic [NPORT-1:0]    req_row [NPORT];
   logic [NPORT-1:0]    req_col [NPORT];
   logic [NPORT-1:0]    gnt_col [NPORT];
   logic [NPORT-1:0]    adv;

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_req
         sa_req_mask #(.NPORT(NPORT), .PW(PW)) u_mask (
            .valid     (in_valid[i]),
            .kind      (in_type[2*i +: 2]),
            .dest      (in_dest[i*PW +: PW]),
            .locked    (locked[i]),
            .held_port (held_port[i*PW +: PW]),
            .out_free  (out_free),
            .out_ready (out_ready),
            .req_vec   (req_row[i]),
            .tgt       (tgt[i*PW +: PW]),
            .fresh     (fresh[i])
         );
      end

      for (genvar o = 0; o < NPORT; o++) begin : g_arb
         for (genvar i = 0; i < NPORT; i++) begin : g_tr
            assign req_col[o][i] = req_row[i][o];
         end
         always_comb begin
            adv[o] = 1'b0;
            for (int i = 0; i < NPORT; i++)
               if (gnt_col[o][i] && fresh[i]) adv[o] = 1'b1;
         end
         sa_rr_arb #(.NREQ(NPORT), .IW(PW)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_col[o]),
            .advance (adv[o]),
            .gnt     (gnt_col[o]),
            .win     (out_src[o*PW +: PW]),
            .any     (out_vld[o])
         );
      end

      for (genvar i = 0; i < NPORT; i++) begin : g_deq
         always_comb begin
            in_deq[i] = 1'b0;
            for (int o = 0; o < NPORT; o++)
               if (gnt_col[o][i]) in_deq[i] = 1'b1;
         end
      end
   endgenerate

   assign in_gnt_port = tgt;

   sa_lock_state #(.NPORT(NPORT), .PW(PW)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .deq       (in_deq),
      .gnt_port  (tgt),
      .kind      (in_type),
      .fresh     (fresh),
      .locked    (locked),
      .held_port (held_port),
      .out_free  (out_free)
   );

endmodule

// File: rtl/sw_alloc_chk.sv
module sw_alloc_chk #(
   parameter int NPORT = 4,
   parameter int PW    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NPORT-1:0]    in_valid,
   input logic [2*NPORT-1:0]  in_type,
   input logic [NPORT-1:0]    out_ready,
   input logic [NPORT-1:0]    in_deq,
   input logic [NPORT*PW-1:0] in_gnt_port,
   input logic [NPORT-1:0]    out_vld,
   input logic [NPORT*PW-1:0] out_src,
   input logic [NPORT-1:0]    locked,
   input logic [NPORT*PW-1:0] held_port,
   input logic [NPORT-1:0]    out_free
);
   logic [NPORT-1:0] owned;

   always_comb begin
      owned = '0;
      for (int i = 0; i < NPORT; i++)
         for (int o = 0; o < NPORT; o++)
            if (locked[i] && int'(held_port[i*PW +: PW]) == o) owned[o] = 1'b1;
   end

   assert_grant_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_deq) == $countones(out_vld));

   assert_free_matches_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_free == ~owned);

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_in
         assert_ready_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
            in_deq[i] |-> (in_valid[i] && out_ready[in_gnt_port[i*PW +: PW]]));

         assert_no_orphan_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_deq[i] && !locked[i]) |-> (in_type[2*i +: 2] == 2'b00 || in_type[2*i +: 2] == 2'b11));

         assert_head_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_deq[i] && !locked[i] && in_type[2*i +: 2] == 2'b00) |=> locked[i]);

         assert_solo_no_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_deq[i] && !locked[i] && in_type[2*i +: 2] == 2'b11) |=> !locked[i]);

         assert_src_names_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_deq[i] |-> (out_vld[in_gnt_port[i*PW +: PW]]
                           && int'(out_src[in_gnt_port[i*PW +: PW]*PW +: PW]) == i));
      end
      for (genvar o = 0; o < NPORT; o++) begin : g_out
         assert_owner_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[o] && !out_free[o]) |->
               (locked[out_src[o*PW +: PW]]
                && int'(held_port[out_src[o*PW +: PW]*PW +: PW]) == o));
      end
   endgenerate

endmodule

bind sw_alloc sw_alloc_chk #(.NPORT(NPORT), .PW(PW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_type     (in_type),
   .out_ready   (out_ready),
   .in_deq      (in_deq),
   .in_gnt_port (in_gnt_port),
   .out_vld     (out_vld),
   .out_src     (out_src),
   .locked      (locked),
   .held_port   (held_port),
   .out_free    (out_free)
);

// File: tb/sim_sw_alloc.sv
module sim_sw_alloc;
   localparam int N  = 4;
   localparam int PW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    in_valid = '0;
   logic [2*N-1:0]  in_type = '0;
   logic [N*PW-1:0] in_dest = '0;
   logic [N-1:0]    out_ready = '0;
   logic [N-1:0]    in_deq;
   logic [N*PW-1:0] in_gnt_port;
   logic [N-1:0]    out_vld;
   logic [N*PW-1:0] out_src;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sw_alloc #(.NPORT(N)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
      .in_dest(in_dest), .out_ready(out_ready), .in_deq(in_deq),
      .in_gnt_port(in_gnt_port), .out_vld(out_vld), .out_src(out_src)
   );

   // behavioural model state
   bit m_lock [N];
   int m_port [N];
   bit m_free [N];
   int m_ptr  [N];
   bit e_vld  [N];
   int e_src  [N];
   bit e_deq  [N];
   bit rq_ok  [N];
   int rq_t   [N];

   task automatic chk(input bit cond, input string tag, input int act, input int exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_lock[i] = 0; m_port[i] = 0; m_free[i] = 1; m_ptr[i] = 0;
      end
   endtask

   task automatic model_eval();
      for (int i = 0; i < N; i++) begin
         int ty, d;
         ty = int'(in_type[2*i +: 2]);
         d  = int'(in_dest[i*PW +: PW]);
         rq_t[i]  = m_lock[i] ? m_port[i] : d;
         rq_ok[i] = in_valid[i] && out_ready[rq_t[i]] &&
                    (m_lock[i] || ((ty == 0 || ty == 3) && m_free[rq_t[i]]));
      end
      for (int o = 0; o < N; o++) begin
         e_vld[o] = 0; e_src[o] = 0;
         for (int k = 0; k < N; k++) begin
            int idx;
            idx = (m_ptr[o] + k) % N;
            if (!e_vld[o] && rq_ok[idx] && rq_t[idx] == o) begin
               e_vld[o] = 1; e_src[o] = idx;
            end
         end
      end
      for (int i = 0; i < N; i++)
         e_deq[i] = rq_ok[i] && e_vld[rq_t[i]] && e_src[rq_t[i]] == i;
   endtask

   task automatic model_commit();
      for (int i = 0; i < N; i++) begin
         if (e_deq[i]) begin
            int ty, o;
            ty = int'(in_type[2*i +: 2]);
            o  = rq_t[i];
            if (!m_lock[i]) begin
               m_ptr[o] = (i + 1) % N;
               if (ty == 0) begin m_lock[i] = 1; m_port[i] = o; m_free[o] = 0; end
            end else if (ty >= 2) begin
               m_lock[i] = 0; m_free[o] = 1;
            end
         end
      end
   endtask

   // compare all outputs against the model; called at mid-cycle
   task automatic compare_model();
      int ed, ev;
      ed = 0; ev = 0;
      model_eval();
      for (int i = 0; i < N; i++) ed |= int'(e_deq[i]) << i;
      for (int o = 0; o < N; o++) ev |= int'(e_vld[o]) << o;
      chk(in_deq == N'(ed), "R4 dequeue vector", int'(in_deq), ed);
      chk(out_vld == N'(ev), "R1 output valid vector", int'(out_vld), ev);
      for (int o = 0; o < N; o++)
         if (e_vld[o])
            chk(int'(out_src[o*PW +: PW]) == e_src[o], "R8 round-robin winner",
                int'(out_src[o*PW +: PW]), e_src[o]);
      for (int i = 0; i < N; i++)
         if (e_deq[i])
            chk(int'(in_gnt_port[i*PW +: PW]) == rq_t[i], "R3 granted port",
                int'(in_gnt_port[i*PW +: PW]), rq_t[i]);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = '0; out_ready = '0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic set_in(input int i, input bit v, input int ty, input int d);
      in_valid[i]          = v;
      in_type[2*i +: 2]    = 2'(ty);
      in_dest[i*PW +: PW]  = PW'(d);
   endtask

   // one directed cycle: inputs already set at negedge
   task automatic dstep(input int exp_deq, input string tag);
      #1;
      chk(int'(in_deq) == exp_deq, tag, int'(in_deq), exp_deq);
      compare_model();
      model_commit();
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      do_reset();

      // R9: idle after reset
      #1;
      chk(in_deq == '0, "R9 no dequeue after reset", int'(in_deq), 0);
      chk(out_vld == '0, "R9 no output valid after reset", int'(out_vld), 0);
      @(negedge clk);

      // R1: head blocked by ready low, then granted
      set_in(0, 1, 0, 1); out_ready = 4'b1101;
      dstep(0, "R1 head blocked by out_ready low");
      out_ready = 4'b1111;
      dstep(1, "R1 head granted when free and ready");

      // R2: unlocked body and tail never granted
      do_reset();
      out_ready = '1;
      set_in(2, 1, 1, 3);
      dstep(0, "R2 unlocked body refused");
      set_in(2, 1, 2, 3);
      dstep(0, "R2 unlocked tail refused");
      in_valid = '0;

      // R5 R3 R6 R8: packet locking on output 2
      do_reset();
      out_ready = '1;
      for (int i = 0; i < N; i++) set_in(i, 1, 0, 2);
      dstep(4'b0001, "R8 first winner is input 0");
      set_in(0, 1, 1, 3);
      dstep(4'b0001, "R5 others masked while input 0 holds output 2");
      out_ready = 4'b1011;
      dstep(0, "R3 locked body waits for out_ready");
      out_ready = '1;
      set_in(0, 1, 2, 1);
      dstep(4'b0001, "R3 tail follows stored port, not its field");
      set_in(0, 0, 0, 0);
      dstep(4'b0010, "R6 output released, next head wins");
      set_in(1, 1, 2, 0);
      dstep(4'b0010, "R6 tail of input 1 granted");
      set_in(1, 1, 0, 2);
      set_in(2, 0, 0, 0);
      dstep(4'b1000, "R8 pointer past input 1 picks input 3");
      in_valid = '0;

      // R7: single-flit packets
      do_reset();
      out_ready = '1;
      set_in(3, 1, 3, 1);
      dstep(4'b1000, "R7 single-flit granted");
      set_in(2, 1, 3, 1);
      dstep(4'b0100, "R7 output still free, R8 wraps to input 2");
      set_in(2, 0, 0, 0);
      set_in(3, 1, 0, 1);
      dstep(4'b1000, "R7 head wins output after single-flit");
      in_valid = '0;

      // sweep of mixed traffic against the model
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         for (int i = 0; i < N; i++) begin
            int r, ty;
            r = int'($urandom_range(0, 99));
            if (m_lock[i]) ty = (r < 55) ? 1 : (r < 90) ? 2 : 0;
            else           ty = (r < 55) ? 0 : (r < 85) ? 3 : (r < 93) ? 1 : 2;
            set_in(i, $urandom_range(0, 9) < 8, ty, int'($urandom_range(0, N-1)));
         end
         for (int o = 0; o < N; o++) out_ready[o] = ($urandom_range(0, 3) != 0);
         #1;
         compare_model();
         model_commit();
         @(negedge clk);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule